// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This block sits next to a small CPU core and decides when one of six event sources gets control. The six sources are: an undefined-instruction exception, a coprocessor fault, an emulator-trap instruction, a software-interrupt instruction carrying an 8-bit operand, a step-trace trap and the non-maskable interrupt pin. Every event pulse is latched. One event is chosen by a fixed priority, and each event has its own acceptance rule. For the chosen event the block computes the handler vector and the rewritten processor status.

After an event is accepted, the block runs a fixed entry sequence. It pushes the unmodified status word onto the system stack, then pushes the program counter. In the final cycle it presents the new stack-select, interrupt-enable and level-mask values together with a branch strobe and the vector number. Events that lose arbitration, or that arrive while a sequence is running, stay latched. They are taken in later sequences.

The core supplies its current status fields, its program counter and an instruction-boundary strobe. The non-maskable interrupt is only taken on that boundary, and only when the level mask is above its fixed level of 15.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset no stack write, status update or branch strobe is asserted, and none appears while no event is pending.
- R2: An event pulse sampled at clock edge E gives a stack write in the cycles after edges E+1 and E+2. The status update and branch strobes follow together for exactly one cycle after edge E+3, with no stack write in that cycle. At least one idle cycle separates two entry sequences.
- R3: The first stack write carries the status word as it was at acceptance: bit 6 is the stack-select flag, bit 5 the interrupt-enable flag, bits 4:0 the level mask and the upper bits zero. The second stack write carries the program counter. Every entry drives the new stack-select value to 0.
- R4: An undefined-instruction exception is always accepted, branches to vector 14, clears the interrupt-enable flag and leaves the level mask unchanged.
- R5: A coprocessor fault is always accepted and clears the interrupt-enable flag. It branches to vector 7 when the fault-type input was 0 (coprocessor absent) and to vector 8 when it was 1 (coprocessor error), as sampled with the pulse.
- R6: An emulator-trap instruction is always accepted, branches to vector 9, sets the level mask to 4 and leaves the interrupt-enable flag unchanged.
- R7: A software-interrupt instruction is always accepted, branches to the vector given by its 8-bit operand (0 to 255, sampled with the pulse), clears the interrupt-enable flag and leaves the level mask unchanged.
- R8: A step-trace trap is always accepted, branches to vector 12, sets the level mask to 4 and leaves the interrupt-enable flag unchanged.
- R9: A latched non-maskable interrupt is accepted only in a cycle where the boundary strobe is high and the level mask is greater than 15. When taken, it branches to vector 15, sets the level mask to 15 and leaves the interrupt-enable flag unchanged. Otherwise it stays latched, with no stack write.
- R10: When several events are latched, they are taken one per sequence in this order: undefined instruction, coprocessor fault, emulator trap, software interrupt, step trace, non-maskable interrupt.
- R11: An event pulse arriving during an entry sequence does not change that sequence's outputs. It is taken in a later sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_undef_i | input | 1 | Undefined-instruction pulse |
| ev_cop_i | input | 1 | Coprocessor fault pulse |
| cop_err_i | input | 1 | Fault type with ev_cop_i: 0 absent, 1 error |
| ev_emu_i | input | 1 | Emulator-trap instruction pulse |
| ev_swi_i | input | 1 | Software-interrupt instruction pulse |
| swi_num_i | input | 8 | Software-interrupt vector operand |
| ev_step_i | input | 1 | Step-trace trap pulse |
| ev_nmi_i | input | 1 | Non-maskable interrupt pulse |
| insn_end_i | input | 1 | Instruction-boundary strobe |
| ps_stack_i | input | 1 | Current stack-select flag |
| ps_ien_i | input | 1 | Current interrupt-enable flag |
| ps_lvl_i | input | 5 | Current level mask |
| pc_i | input | 32 | Current program counter |
| stk_we_o | output | 1 | Stack write strobe |
| stk_data_o | output | 32 | Stack write data |
| ps_upd_o | output | 1 | Status update strobe |
| ps_stack_o | output | 1 | New stack-select flag |
| ps_ien_o | output | 1 | New interrupt-enable flag |
| ps_lvl_o | output | 5 | New level mask |
| vec_o | output | 8 | Handler vector number |
| branch_o | output | 1 | Branch strobe |

## Verification
The hardest case to reach is a non-maskable interrupt that is latched but held back, because the boundary strobe is low or the level mask is 15 or below, while other events win arbitration around it. The random stimulus draws the level mask over its full 0 to 31 range and the boundary strobe independently, for any subset of the six events. It then checks that the held interrupt produces no stack writes for several cycles, raises the mask above 15 and expects the interrupt to be taken last. A directed case injects a new pulse in the middle of a running sequence to confirm that the pulse is latched without disturbing the sequence in progress.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
    localparam int NUM_EV = 6;
    localparam int VEC_W  = 8;

    // Index order is the priority order: lower index wins.
    typedef enum logic [2:0] {
        EV_UNDEF = 3'd0,
        EV_COP   = 3'd1,
        EV_EMU   = 3'd2,
        EV_SWI   = 3'd3,
        EV_STEP  = 3'd4,
        EV_NMI   = 3'd5
    } ev_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_PS,
        ST_PUSH_PC,
        ST_COMMIT
    } st_e;

    localparam logic [VEC_W-1:0] VEC_UNDEF   = 8'd14;
    localparam logic [VEC_W-1:0] VEC_EMU     = 8'd9;
    localparam logic [VEC_W-1:0] VEC_STEP    = 8'd12;
    localparam logic [VEC_W-1:0] VEC_NMI     = 8'd15;
    localparam logic [VEC_W-1:0] VEC_COP_ABS = 8'd7;
    localparam logic [VEC_W-1:0] VEC_COP_ERR = 8'd8;
endpackage

// File: rtl/trap_pending.sv
`timescale 1ns/1ps
module trap_pending
    import trap_pkg::*;
#(
    parameter int NUM = NUM_EV,
    parameter int VW  = VEC_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    input  logic [VW-1:0]  swi_num_i,
    input  logic           cop_err_i,
    output logic [NUM-1:0] pend_o,
    output logic [VW-1:0]  swi_num_o,
    output logic           cop_err_o
);
    typedef struct packed {
        logic [NUM-1:0] pend;
        logic [VW-1:0]  swi;
        logic           cop;
    } pend_t;

    pend_t q, d;

    always_comb begin
        d      = q;
        // A fresh pulse wins over a clear in the same cycle.
        d.pend = (q.pend & ~clr_i) | set_i;
        if (set_i[EV_SWI]) d.swi = swi_num_i;
        if (set_i[EV_COP]) d.cop = cop_err_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign pend_o    = q.pend;
    assign swi_num_o = q.swi;
    assign cop_err_o = q.cop;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_hold
            AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (pend_o[g] && !clr_i[g]) |=> pend_o[g]); // R11
        end
    endgenerate
endmodule

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NUM       = NUM_EV,
    parameter int LVL_W     = 5,
    parameter int NMI_LEVEL = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NUM-1:0]   pend_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             insn_end_i,
    input  logic             idle_i,
    output logic [NUM-1:0]   grant_o,
    output logic             take_o
);
    localparam logic [NUM-1:0]   ONE     = NUM'(1);
    localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NMI_LEVEL);

    logic           nmi_ok;
    logic [NUM-1:0] elig;
    logic [NUM-1:0] first;

    always_comb begin
        nmi_ok       = insn_end_i && (lvl_i > NMI_LVL);
        elig         = pend_i;
        elig[EV_NMI] = pend_i[EV_NMI] & nmi_ok;
        first        = elig & (~elig + ONE);
        grant_o      = idle_i ? first : '0;
        take_o       = |grant_o;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o)); // R10
    AST_NMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o[EV_NMI] |-> (insn_end_i && lvl_i > NMI_LVL)); // R9

    generate
        for (genvar g = 1; g < NUM; g++) begin : g_prio
            AST_HIGHER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
                grant_o[g] |-> (pend_i[g-1:0] == '0)); // R10
        end
    endgenerate
endmodule

// File: rtl/trap_entry_seq.sv
`timescale 1ns/1ps
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int NUM         = NUM_EV,
    parameter int PC_W        = 32,
    parameter int LVL_W       = 5,
    parameter int VW          = VEC_W,
    parameter int BLOCK_LEVEL = 4,
    parameter int NMI_LEVEL   = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             take_i,
    input  logic [NUM-1:0]   grant_i,
    input  logic [VW-1:0]    swi_num_i,
    input  logic             cop_err_i,
    input  logic             ps_stack_i,
    input  logic             ps_ien_i,
    input  logic [LVL_W-1:0] ps_lvl_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             idle_o,
    output logic             stk_we_o,
    output logic [PC_W-1:0]  stk_data_o,
    output logic             ps_upd_o,
    output logic             ps_stack_o,
    output logic             ps_ien_o,
    output logic [LVL_W-1:0] ps_lvl_o,
    output logic [VW-1:0]    vec_o,
    output logic             branch_o
);
    localparam int SW = LVL_W + 2;
    localparam logic [LVL_W-1:0] BLK_LVL = LVL_W'(BLOCK_LEVEL);
    localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NMI_LEVEL);

    typedef struct packed {
        st_e              st;
        ev_e              kind;
        logic [SW-1:0]    ps_word;
        logic [PC_W-1:0]  pc;
        logic [VW-1:0]    vec;
        logic             ien;
        logic [LVL_W-1:0] lvl;
    } seq_t;

    seq_t q, d;
    ev_e  sel;

    always_comb begin
        sel = EV_UNDEF;
        for (int k = 0; k < NUM; k++) begin
            if (grant_i[k]) sel = ev_e'(k[2:0]);
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (take_i) begin
                    d.st      = ST_PUSH_PS;
                    d.kind    = sel;
                    d.ps_word = {ps_stack_i, ps_ien_i, ps_lvl_i};
                    d.pc      = pc_i;
                    d.ien     = ps_ien_i;
                    d.lvl     = ps_lvl_i;
                    unique case (sel)
                        EV_UNDEF: begin d.vec = VEC_UNDEF; d.ien = 1'b0; end
                        EV_COP: begin
                            d.vec = cop_err_i ? VEC_COP_ERR : VEC_COP_ABS;
                            d.ien = 1'b0;
                        end
                        EV_EMU:  begin d.vec = VEC_EMU;   d.lvl = BLK_LVL; end
                        EV_SWI:  begin d.vec = swi_num_i; d.ien = 1'b0; end
                        EV_STEP: begin d.vec = VEC_STEP;  d.lvl = BLK_LVL; end
                        EV_NMI:  begin d.vec = VEC_NMI;   d.lvl = NMI_LVL; end
                        default: d.vec = VEC_UNDEF;
                    endcase
                end
            end
            ST_PUSH_PS: d.st = ST_PUSH_PC;
            ST_PUSH_PC: d.st = ST_COMMIT;
            ST_COMMIT:  d.st = ST_IDLE;
            default:    d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign idle_o     = (q.st == ST_IDLE);
    assign stk_we_o   = (q.st == ST_PUSH_PS) || (q.st == ST_PUSH_PC);
    assign stk_data_o = (q.st == ST_PUSH_PS) ? {{(PC_W-SW){1'b0}}, q.ps_word} : q.pc;
    assign ps_upd_o   = (q.st == ST_COMMIT);
    assign branch_o   = (q.st == ST_COMMIT);
    assign ps_stack_o = 1'b0;
    assign ps_ien_o   = q.ien;
    assign ps_lvl_o   = q.lvl;
    assign vec_o      = q.vec;

    AST_PUSH_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stk_we_o) |=> stk_we_o); // R2
    AST_BRANCH_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        branch_o |-> ($past(stk_we_o) && $past(stk_we_o, 2))); // R2
    AST_BRANCH_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        branch_o |=> !branch_o); // R2
    AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idle_o && !$rose(stk_we_o)) |-> $stable(vec_o)); // R11
    AST_EMU_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ps_upd_o && q.kind == EV_EMU) |-> (ps_lvl_o == BLK_LVL)); // R6
    AST_STEP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ps_upd_o && q.kind == EV_STEP) |-> (ps_lvl_o == BLK_LVL)); // R8
    AST_NMI_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ps_upd_o && q.kind == EV_NMI) |-> (ps_lvl_o == NMI_LVL && vec_o == VEC_NMI)); // R9
    AST_UNDEF_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ps_upd_o && q.kind == EV_UNDEF) |-> !ps_ien_o); // R4
endmodule

// File: rtl/trap_entry_ctrl.sv
`timescale 1ns/1ps
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int LVL_W       = 5,
    parameter int BLOCK_LEVEL = 4,
    parameter int NMI_LEVEL   = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ev_undef_i,
    input  logic             ev_cop_i,
    input  logic             cop_err_i,
    input  logic             ev_emu_i,
    input  logic             ev_swi_i,
    input  logic [VEC_W-1:0] swi_num_i,
    input  logic             ev_step_i,
    input  logic             ev_nmi_i,
    input  logic             insn_end_i,
    input  logic             ps_stack_i,
    input  logic             ps_ien_i,
    input  logic [LVL_W-1:0] ps_lvl_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             stk_we_o,
    output logic [PC_W-1:0]  stk_data_o,
    output logic             ps_upd_o,
    output logic             ps_stack_o,
    output logic             ps_ien_o,
    output logic [LVL_W-1:0] ps_lvl_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             branch_o
);
    logic [NUM_EV-1:0] set_ev;
    logic [NUM_EV-1:0] pend;
    logic [NUM_EV-1:0] grant;
    logic [VEC_W-1:0]  swi_lat;
    logic              cop_lat;
    logic              idle;
    logic              take;

    always_comb begin
        set_ev           = '0;
        set_ev[EV_UNDEF] = ev_undef_i;
        set_ev[EV_COP]   = ev_cop_i;
        set_ev[EV_EMU]   = ev_emu_i;
        set_ev[EV_SWI]   = ev_swi_i;
        set_ev[EV_STEP]  = ev_step_i;
        set_ev[EV_NMI]   = ev_nmi_i;
    end

    trap_pending #(.NUM(NUM_EV), .VW(VEC_W)) u_pend (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_ev),
        .clr_i     (grant),
        .swi_num_i (swi_num_i),
        .cop_err_i (cop_err_i),
        .pend_o    (pend),
        .swi_num_o (swi_lat),
        .cop_err_o (cop_lat)
    );

    trap_arbiter #(.NUM(NUM_EV), .LVL_W(LVL_W), .NMI_LEVEL(NMI_LEVEL)) u_arb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pend_i     (pend),
        .lvl_i      (ps_lvl_i),
        .insn_end_i (insn_end_i),
        .idle_i     (idle),
        .grant_o    (grant),
        .take_o     (take)
    );

    trap_entry_seq #(
        .NUM(NUM_EV), .PC_W(PC_W), .LVL_W(LVL_W), .VW(VEC_W),
        .BLOCK_LEVEL(BLOCK_LEVEL), .NMI_LEVEL(NMI_LEVEL)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .take_i     (take),
        .grant_i    (grant),
        .swi_num_i  (swi_lat),
        .cop_err_i  (cop_lat),
        .ps_stack_i (ps_stack_i),
        .ps_ien_i   (ps_ien_i),
        .ps_lvl_i   (ps_lvl_i),
        .pc_i       (pc_i),
        .idle_o     (idle),
        .stk_we_o   (stk_we_o),
        .stk_data_o (stk_data_o),
        .ps_upd_o   (ps_upd_o),
        .ps_stack_o (ps_stack_o),
        .ps_ien_o   (ps_ien_o),
        .ps_lvl_o   (ps_lvl_o),
        .vec_o      (vec_o),
        .branch_o   (branch_o)
    );

    AST_NO_WRITE_AT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        branch_o |-> (!stk_we_o && ps_upd_o && !ps_stack_o)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle && !take) |=> !stk_we_o); // R1
endmodule

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        ev_undef, ev_cop, cop_err, ev_emu, ev_swi, ev_step, ev_nmi;
    logic [7:0]  swi_num;
    logic        insn_end, ps_stack, ps_ien;
    logic [4:0]  ps_lvl;
    logic [31:0] pc;
    logic        stk_we, ps_upd, ps_stack_n, ps_ien_n, branch;
    logic [31:0] stk_data;
    logic [4:0]  ps_lvl_n;
    logic [7:0]  vec;

    trap_entry_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .ev_undef_i(ev_undef), .ev_cop_i(ev_cop), .cop_err_i(cop_err),
        .ev_emu_i(ev_emu), .ev_swi_i(ev_swi), .swi_num_i(swi_num),
        .ev_step_i(ev_step), .ev_nmi_i(ev_nmi), .insn_end_i(insn_end),
        .ps_stack_i(ps_stack), .ps_ien_i(ps_ien), .ps_lvl_i(ps_lvl), .pc_i(pc),
        .stk_we_o(stk_we), .stk_data_o(stk_data), .ps_upd_o(ps_upd),
        .ps_stack_o(ps_stack_n), .ps_ien_o(ps_ien_n), .ps_lvl_o(ps_lvl_n),
        .vec_o(vec), .branch_o(branch)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [5:0] bpend;
    logic [7:0] bswi;
    logic       bcop;

    task automatic chk(input bit ok, input string rq, input logic [39:0] act, input logic [39:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // bit order: 0 undef, 1 cop, 2 emu, 3 swi, 4 step, 5 nmi
    function automatic int pick(input logic [5:0] p);
        logic [5:0] e = p;
        if (!(insn_end && ps_lvl > 5'd15)) e[5] = 1'b0;
        for (int k = 0; k < 6; k++) if (e[k]) return k;
        return -1;
    endfunction

    function automatic string rtag(input int k);
        case (k)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] exp_vec(input int k);
        case (k)
            0: return 8'd14;
            1: return bcop ? 8'd8 : 8'd7;
            2: return 8'd9;
            3: return bswi;
            4: return 8'd12;
            default: return 8'd15;
        endcase
    endfunction

    function automatic logic exp_ien(input int k);
        return (k == 0 || k == 1 || k == 3) ? 1'b0 : ps_ien;
    endfunction

    function automatic logic [4:0] exp_lvl(input int k);
        if (k == 2 || k == 4) return 5'd4;
        if (k == 5) return 5'd15;
        return ps_lvl;
    endfunction

    task automatic drive_pulses(input logic [5:0] m);
        {ev_nmi, ev_step, ev_swi, ev_emu, ev_cop, ev_undef} = m;
    endtask

    task automatic fire(input logic [5:0] m, input logic [7:0] sw, input logic ce);
        drive_pulses(m);
        swi_num = sw;
        cop_err = ce;
        bpend |= m;
        if (m[3]) bswi = sw;
        if (m[1]) bcop = ce;
        @(negedge clk);
        drive_pulses(6'd0);
    endtask

    task automatic observe_one(input int k, input logic [5:0] inj, input string ctx);
        int w = 0;
        while (!stk_we && w < 6) begin
            chk(!ps_upd && !branch, {ctx, " R2 no commit before pushes"}, {ps_upd, branch}, 0);
            @(negedge clk);
            w++;
        end
        chk(stk_we, {ctx, " R2 status push strobe"}, stk_we, 1);
        chk(stk_data == {25'd0, ps_stack, ps_ien, ps_lvl}, {ctx, " R3 pushed status word"},
            stk_data, {25'd0, ps_stack, ps_ien, ps_lvl});
        if (inj != 6'd0) begin
            drive_pulses(inj);
            bpend |= inj;
        end
        @(negedge clk);
        drive_pulses(6'd0);
        chk(stk_we && stk_data == pc, {ctx, " R3 pushed pc word"}, stk_data, pc);
        @(negedge clk);
        chk(ps_upd && branch && !stk_we, {ctx, " R2 commit strobes"}, {ps_upd, branch, stk_we}, 3'b110);
        chk(vec == exp_vec(k), {ctx, " ", rtag(k), " vector"}, vec, exp_vec(k));
        chk(ps_stack_n == 1'b0, {ctx, " R3 stack select cleared"}, ps_stack_n, 0);
        chk(ps_ien_n == exp_ien(k), {ctx, " ", rtag(k), " new ien"}, ps_ien_n, exp_ien(k));
        chk(ps_lvl_n == exp_lvl(k), {ctx, " ", rtag(k), " new level"}, ps_lvl_n, exp_lvl(k));
        bpend[k] = 1'b0;
        @(negedge clk);
        chk(!branch && !ps_upd && !stk_we, {ctx, " R2 single commit then idle"}, {branch, ps_upd, stk_we}, 0);
    endtask

    task automatic drain(input string ctx);
        int k = pick(bpend);
        while (k >= 0) begin
            observe_one(k, 6'd0, ctx);
            k = pick(bpend);
        end
    endtask

    task automatic quiet(input int n, input string rq);
        repeat (n) begin
            chk(!stk_we && !branch && !ps_upd, rq, {stk_we, branch, ps_upd}, 0);
            @(negedge clk);
        end
    endtask

    task automatic set_ps(input logic s, input logic i, input logic [4:0] l, input logic e, input logic [31:0] p);
        ps_stack = s; ps_ien = i; ps_lvl = l; insn_end = e; pc = p;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        drive_pulses(6'd0);
        swi_num = 8'd0; cop_err = 1'b0;
        set_ps(1'b1, 1'b1, 5'd20, 1'b1, 32'h0000_1000);
        bpend = 6'd0; bswi = 8'd0; bcop = 1'b0;
        repeat (4) @(negedge clk);
        chk(!stk_we && !branch && !ps_upd, "R1 outputs in reset", {stk_we, branch, ps_upd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        quiet(4, "R1 idle after reset");

        // Directed: each source alone.
        fire(6'b000001, 8'd0, 1'b0);   drain("dir");
        fire(6'b001000, 8'd0, 1'b0);   drain("dir swi0");
        set_ps(1'b0, 1'b1, 5'd7, 1'b0, 32'hDEAD_BEEF);
        fire(6'b001000, 8'd255, 1'b0); drain("dir swi255");
        fire(6'b000010, 8'd0, 1'b0);   drain("dir cop absent");
        fire(6'b000010, 8'd0, 1'b1);   drain("dir cop error");
        set_ps(1'b1, 1'b1, 5'd20, 1'b1, 32'h0000_2000);
        fire(6'b000100, 8'd0, 1'b0);   drain("dir emu");
        fire(6'b010000, 8'd0, 1'b0);   drain("dir step");

        // NMI gating.
        set_ps(1'b1, 1'b0, 5'd15, 1'b1, 32'h0000_3000);
        fire(6'b100000, 8'd0, 1'b0);
        quiet(6, "R9 level 15 not above mask");
        ps_lvl = 5'd31; insn_end = 1'b0;
        quiet(4, "R9 no boundary strobe");
        insn_end = 1'b1;
        drain("R9 released");
        chk(bpend == 6'd0, "R9 model drained", bpend, 0);

        // Priority: all six at once.
        set_ps(1'b1, 1'b1, 5'd31, 1'b1, 32'h0000_4000);
        fire(6'b111111, 8'd77, 1'b1);
        drain("R10 all pending");

        // Pulse during a running sequence.
        fire(6'b000001, 8'd0, 1'b0);
        observe_one(0, 6'b000100, "R11 inject");
        drain("R11 later");

        // Random mix.
        for (int it = 0; it < 300; it++) begin
            set_ps(1'($urandom), 1'($urandom), 5'($urandom), 1'($urandom), $urandom);
            fire(6'($urandom), 8'($urandom), 1'($urandom));
            drain("rnd R10");
            if (bpend != 6'd0) begin
                quiet(3, "R9 held while masked");
                ps_lvl = 5'd16 + 5'($urandom % 16);
                insn_end = 1'b1;
                drain("rnd R9");
            end
            chk(bpend == 6'd0, "R10 model drained", bpend, 0);
        end
        quiet(3, "R1 idle at end");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule